// File: doc/BRIEF.md
# Infrared Pulse-Distance Frame Receiver

This block turns a demodulated infrared remote-control line into data words. The line is looked at only on ticks of a slow sampling enable. Each sample passes through a two-stage synchronizer and a three-sample majority vote. The receiver then waits for a header. A header is a low pulse followed by a high pulse, and both widths must fall inside programmable windows. Once a header is accepted, the receiver measures the number of ticks between successive falling edges of the line. A long spacing gives a 1 and a short spacing gives a 0. The bits are packed into a wide buffer, first bit at bit 0.

A frame has no fixed length. It ends when the time since the last falling edge reaches a programmed maximum cycle, or when the line stays low longer than a programmed limit. At that point the data, the bit count, the ending cause and an overflow flag are published together in one cycle. A one-clock completion pulse marks that cycle, and the receiver goes back to looking for a header. A separate one-clock pulse marks each accepted header. A host or a bus wrapper supplies the configuration values and reacts to the two pulses.

Top module: `irpd_receiver`

## Requirements
- R1: The line and all width and period counters are sampled and advanced only in clock cycles where `sample_tick` is high. Activity on `ir_in` while no ticks occur has no effect.
- R2: The line passes through two synchronizer samples and a majority vote over the last three samples. A low lasting a single tick inside a high phase changes no decoded bit.
- R3: A header is a low run of L samples with `cfg_ldr_low_min` ≤ L ≤ `cfg_ldr_low_max`, then a high run of H samples with `cfg_ldr_high_min` ≤ H ≤ `cfg_ldr_high_max`, ended by a falling edge. Accepting it raises `leader_irq` for exactly one clock and starts bit reception at that falling edge.
- R4: A header whose low or high run lies outside its window produces no `leader_irq`, starts no frame, and leaves the published registers unchanged.
- R5: Each falling-edge-to-falling-edge spacing P (in ticks) gives bit 1 when P ≥ `cfg_one_period` and bit 0 otherwise. The first bit of a frame lands in `rx_data[0]`, the next in `rx_data[1]`, and so on.
- R6: At most MAX_BITS (default 72) bits are stored. Further bits are dropped, `rx_count` stays at MAX_BITS and `rx_overflow` is published as 1.
- R7: When the ticks since the last falling edge reach `cfg_max_cycle`, the frame completes with `rx_cause` = 2'b01. A spacing of `cfg_max_cycle`-1 is still decoded as a bit.
- R8: When the number of consecutive low samples during reception exceeds `cfg_low_limit`, the frame completes with `rx_cause` = 2'b10. A low run equal to the limit does not end the frame. If both conditions hit in the same sample, 2'b01 wins.
- R9: On completion, `rx_data`, `rx_count`, `rx_cause` and `rx_overflow` change in the same clock as a one-clock `done_irq`, and at no other time. Data bits at or above `rx_count` read 0. All four outputs reset to 0.
- R10: After completion the receiver waits for a new header. Data-like pulses without a valid header produce no interrupt and no register update.
- R11: While `rx_enable` is low the receiver is held in the header-wait state and a partial frame is discarded. No completion is reported for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sampling enable, one clock wide |
| ir_in | input | 1 | Asynchronous demodulated remote line, idle high |
| rx_enable | input | 1 | Receiver enable; low forces header wait |
| cfg_ldr_low_min | input | CNT_W | Minimum header low width in ticks |
| cfg_ldr_low_max | input | CNT_W | Maximum header low width in ticks |
| cfg_ldr_high_min | input | CNT_W | Minimum header high width in ticks |
| cfg_ldr_high_max | input | CNT_W | Maximum header high width in ticks |
| cfg_one_period | input | CNT_W | Spacing at or above which a bit is 1 |
| cfg_max_cycle | input | CNT_W | Ticks without a falling edge that end a frame |
| cfg_low_limit | input | CNT_W | Low run length that, when exceeded, ends a frame |
| leader_irq | output | 1 | One-clock pulse on header acceptance |
| done_irq | output | 1 | One-clock pulse when results are published |
| rx_data | output | MAX_BITS | Received bits, first bit at bit 0 |
| rx_count | output | $clog2(MAX_BITS+1) | Number of stored bits |
| rx_cause | output | 2 | Completion cause: 01 max cycle, 10 excess low |
| rx_overflow | output | 1 | More than MAX_BITS bits were seen |

## Verification
The assertions check several rules on every clock. The filtered level moves only on a tick. Header pulses are single clocks and come only out of the header-high phase. The published registers change only with a completion pulse, which always carries a legal cause. The count never exceeds its cap, and overflow implies a full count. A low enable always leaves the receiver waiting for a header. What only the bench's scenarios can show is the decoded content: bit values at both sides of the one-threshold, the max-cycle and low-limit boundaries, header window rejection, glitch suppression, the frame discarded by enable, and the 72-bit cap with its overflow flag.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_HLOW  = 2'd1,
        ST_HHIGH = 2'd2,
        ST_BITS  = 2'd3
    } irpd_state_e;

    localparam logic [1:0] CAUSE_NONE   = 2'b00;
    localparam logic [1:0] CAUSE_MAXCYC = 2'b01;
    localparam logic [1:0] CAUSE_LOWLIM = 2'b10;

endpackage

// File: rtl/irpd_in_filter.sv
module irpd_in_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_raw,
    output logic lvl,
    output logic stb
);

    typedef struct packed {
        logic       s1;
        logic       s2;
        logic [1:0] hist;
        logic       lvl;
        logic       stb;
    } filt_regs_t;

    filt_regs_t q, d;

    always_comb begin
        d     = q;
        d.stb = tick;
        if (tick) begin
            d.s1   = line_raw;
            d.s2   = q.s1;
            d.hist = {q.hist[0], q.s2};
            d.lvl  = (q.s2 & q.hist[0]) | (q.s2 & q.hist[1]) | (q.hist[0] & q.hist[1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: 1'b1, s2: 1'b1, hist: 2'b11, lvl: 1'b1, stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign lvl = q.lvl;
    assign stb = q.stb;

    // R1: the filtered level may only move on a sampling tick
    p_level_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q.lvl));

endmodule

// File: rtl/irpd_frame_ctrl.sv
module irpd_frame_ctrl
    import irpd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_BITS = 72,
    localparam int NB_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                stb,
    input  logic                lvl,
    input  logic [CNT_W-1:0]    low_min,
    input  logic [CNT_W-1:0]    low_max,
    input  logic [CNT_W-1:0]    high_min,
    input  logic [CNT_W-1:0]    high_max,
    input  logic [CNT_W-1:0]    one_period,
    input  logic [CNT_W-1:0]    max_cycle,
    input  logic [CNT_W-1:0]    low_limit,
    output logic                ldr_pulse,
    output logic                done_pulse,
    output logic [MAX_BITS-1:0] out_data,
    output logic [NB_W-1:0]     out_count,
    output logic [1:0]          out_cause,
    output logic                out_ovf
);

    localparam logic [NB_W-1:0] NB_CAP = NB_W'(MAX_BITS);

    typedef struct packed {
        irpd_state_e         st;
        logic                prev;
        logic [CNT_W-1:0]    run;
        logic [CNT_W-1:0]    elap;
        logic [CNT_W-1:0]    lowrun;
        logic [NB_W-1:0]     nb;
        logic                ovf;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] o_data;
        logic [NB_W-1:0]     o_cnt;
        logic [1:0]          o_cause;
        logic                o_ovf;
        logic                ldr;
        logic                done;
    } ctrl_regs_t;

    ctrl_regs_t q, d;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    logic             fall_s, rise_s;
    logic [CNT_W-1:0] run_inc, elap_inc, low_inc;
    logic             bit_val, end_max, end_low;
    logic             low_ok, high_ok;

    always_comb begin
        fall_s   = q.prev & ~lvl;
        rise_s   = ~q.prev & lvl;
        run_inc  = sat_inc(q.run);
        elap_inc = sat_inc(q.elap);
        low_inc  = lvl ? '0 : sat_inc(q.lowrun);
        bit_val  = (elap_inc >= one_period);
        end_max  = (elap_inc >= max_cycle);
        end_low  = (low_inc > low_limit);
        low_ok   = (q.run >= low_min) && (q.run <= low_max);
        high_ok  = (q.run >= high_min) && (q.run <= high_max);
    end

    always_comb begin
        d      = q;
        d.ldr  = 1'b0;
        d.done = 1'b0;
        if (!en) begin
            d.st  = ST_WAIT;
            d.nb  = '0;
            d.acc = '0;
            d.ovf = 1'b0;
        end else if (stb) begin
            d.prev = lvl;
            unique case (q.st)
                ST_WAIT: begin
                    if (fall_s) begin
                        d.st  = ST_HLOW;
                        d.run = CNT_W'(1);
                    end
                end
                ST_HLOW: begin
                    if (rise_s) begin
                        d.st  = low_ok ? ST_HHIGH : ST_WAIT;
                        d.run = CNT_W'(1);
                    end else begin
                        d.run = run_inc;
                    end
                end
                ST_HHIGH: begin
                    if (fall_s) begin
                        if (high_ok) begin
                            d.st     = ST_BITS;
                            d.ldr    = 1'b1;
                            d.elap   = '0;
                            d.lowrun = CNT_W'(1);
                            d.nb     = '0;
                            d.acc    = '0;
                            d.ovf    = 1'b0;
                        end else begin
                            d.st  = ST_HLOW;
                            d.run = CNT_W'(1);
                        end
                    end else begin
                        d.run = run_inc;
                    end
                end
                ST_BITS: begin
                    d.elap   = elap_inc;
                    d.lowrun = low_inc;
                    if (end_max || end_low) begin
                        d.st      = ST_WAIT;
                        d.done    = 1'b1;
                        d.o_data  = q.acc;
                        d.o_cnt   = q.nb;
                        d.o_ovf   = q.ovf;
                        d.o_cause = end_max ? CAUSE_MAXCYC : CAUSE_LOWLIM;
                    end else if (fall_s) begin
                        d.elap = '0;
                        if (q.nb < NB_CAP) begin
                            d.acc[q.nb] = bit_val;
                            d.nb        = q.nb + 1'b1;
                        end else begin
                            d.ovf = 1'b1;
                        end
                    end
                end
                default: d.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_WAIT;
            q.prev    <= 1'b1;
            q.o_cause <= CAUSE_NONE;
        end else begin
            q <= d;
        end
    end

    assign ldr_pulse  = q.ldr;
    assign done_pulse = q.done;
    assign out_data   = q.o_data;
    assign out_count  = q.o_cnt;
    assign out_cause  = q.o_cause;
    assign out_ovf    = q.o_ovf;

    // R3: a header pulse lasts one clock and only follows the header-high phase
    p_leader_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ldr |=> !q.ldr);
    p_leader_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.ldr |-> ($past(q.st) == ST_HHIGH && q.st == ST_BITS));

    // R6: stored count never above cap; overflow only with a full buffer
    p_count_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.nb <= NB_CAP && q.o_cnt <= NB_CAP);
    p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.o_ovf |-> (q.o_cnt == NB_CAP));

    // R7 / R8: every completion carries one of the two legal causes
    p_cause_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.o_cause == CAUSE_MAXCYC || q.o_cause == CAUSE_LOWLIM));

    // R9: published registers move only together with the completion pulse
    p_publish_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.o_data != $past(q.o_data) || q.o_cnt != $past(q.o_cnt) ||
         q.o_cause != $past(q.o_cause) || q.o_ovf != $past(q.o_ovf)) |-> q.done);

    // R11: a low enable leaves the receiver waiting for a header
    p_disable_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.st == ST_WAIT && !q.done));

endmodule

// File: rtl/irpd_receiver.sv
module irpd_receiver #(
    parameter int CNT_W    = 16,
    parameter int MAX_BITS = 72,
    localparam int NB_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                ir_in,
    input  logic                rx_enable,
    input  logic [CNT_W-1:0]    cfg_ldr_low_min,
    input  logic [CNT_W-1:0]    cfg_ldr_low_max,
    input  logic [CNT_W-1:0]    cfg_ldr_high_min,
    input  logic [CNT_W-1:0]    cfg_ldr_high_max,
    input  logic [CNT_W-1:0]    cfg_one_period,
    input  logic [CNT_W-1:0]    cfg_max_cycle,
    input  logic [CNT_W-1:0]    cfg_low_limit,
    output logic                leader_irq,
    output logic                done_irq,
    output logic [MAX_BITS-1:0] rx_data,
    output logic [NB_W-1:0]     rx_count,
    output logic [1:0]          rx_cause,
    output logic                rx_overflow
);

    logic filt_lvl;
    logic filt_stb;

    irpd_in_filter u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .line_raw (ir_in),
        .lvl      (filt_lvl),
        .stb      (filt_stb)
    );

    irpd_frame_ctrl #(
        .CNT_W    (CNT_W),
        .MAX_BITS (MAX_BITS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (rx_enable),
        .stb        (filt_stb),
        .lvl        (filt_lvl),
        .low_min    (cfg_ldr_low_min),
        .low_max    (cfg_ldr_low_max),
        .high_min   (cfg_ldr_high_min),
        .high_max   (cfg_ldr_high_max),
        .one_period (cfg_one_period),
        .max_cycle  (cfg_max_cycle),
        .low_limit  (cfg_low_limit),
        .ldr_pulse  (leader_irq),
        .done_pulse (done_irq),
        .out_data   (rx_data),
        .out_count  (rx_count),
        .out_cause  (rx_cause),
        .out_ovf    (rx_overflow)
    );

endmodule

// File: tb/irpd_receiver_bench.sv
module irpd_receiver_bench;

    localparam int CNT_W    = 16;
    localparam int MAX_BITS = 72;
    localparam int NB_W     = $clog2(MAX_BITS + 1);
    localparam int DIV      = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sample_tick = 1'b0;
    logic                ir_in = 1'b1;
    logic                rx_enable = 1'b1;
    logic                leader_irq, done_irq;
    logic [MAX_BITS-1:0] rx_data;
    logic [NB_W-1:0]     rx_count;
    logic [1:0]          rx_cause;
    logic                rx_overflow;

    logic tick_run = 1'b1;
    int   div_cnt  = 0;
    int   n_ldr    = 0;
    int   n_done   = 0;
    int   checks   = 0;
    int   errors   = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    irpd_receiver #(.CNT_W(CNT_W), .MAX_BITS(MAX_BITS)) u_irpd_receiver (
        .clk              (clk),
        .rst_n            (rst_n),
        .sample_tick      (sample_tick),
        .ir_in            (ir_in),
        .rx_enable        (rx_enable),
        .cfg_ldr_low_min  (16'd8),
        .cfg_ldr_low_max  (16'd12),
        .cfg_ldr_high_min (16'd4),
        .cfg_ldr_high_max (16'd6),
        .cfg_one_period   (16'd6),
        .cfg_max_cycle    (16'd12),
        .cfg_low_limit    (16'd5),
        .leader_irq       (leader_irq),
        .done_irq         (done_irq),
        .rx_data          (rx_data),
        .rx_count         (rx_count),
        .rx_cause         (rx_cause),
        .rx_overflow      (rx_overflow)
    );

    always @(negedge clk) begin
        div_cnt     = (div_cnt + 1) % DIV;
        sample_tick = tick_run && (div_cnt == 0);
    end

    always @(posedge clk) begin
        if (leader_irq) n_ldr <= n_ldr + 1;
        if (done_irq)   n_done <= n_done + 1;
    end

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int nt);
        ir_in = v;
        repeat (nt * DIV) @(negedge clk);
    endtask

    task automatic header(input int lo, input int hi);
        drive(1'b0, lo);
        drive(1'b1, hi);
    endtask

    task automatic send_bit(input logic b);
        drive(1'b0, 2);
        drive(1'b1, b ? 6 : 2);
    endtask

    task automatic end_by_cycle();
        drive(1'b0, 2);
        drive(1'b1, 30);
    endtask

    task automatic end_by_low();
        drive(1'b0, 10);
        drive(1'b1, 30);
    endtask

    task automatic t_reset();
        chk("R9 reset data", 96'(rx_data), 96'd0);
        chk("R9 reset count", 96'(rx_count), 96'd0);
        chk("R9 reset cause", 96'(rx_cause), 96'd0);
        chk("R9 reset overflow", 96'(rx_overflow), 96'd0);
    endtask

    task automatic t_basic();
        int l0 = n_ldr;
        int d0 = n_done;
        logic [7:0] pat = 8'hA5;
        header(10, 5);
        for (int i = 0; i < 8; i++) send_bit(pat[i]);
        end_by_cycle();
        chk("R3 leader pulse count", 96'(n_ldr - l0), 96'd1);
        chk("R9 done pulse count", 96'(n_done - d0), 96'd1);
        chk("R5 data lsb first", 96'(rx_data), 96'h0A5);
        chk("R5 bit count", 96'(rx_count), 96'd8);
        chk("R7 cause max cycle", 96'(rx_cause), 96'd1);
        chk("R6 no overflow", 96'(rx_overflow), 96'd0);
    endtask

    task automatic t_thresholds();
        header(10, 5);
        drive(1'b0, 2); drive(1'b1, 4);   // spacing 6 -> 1
        drive(1'b0, 2); drive(1'b1, 3);   // spacing 5 -> 0
        drive(1'b0, 2); drive(1'b1, 9);   // spacing 11 -> 1 (one below max)
        end_by_cycle();
        chk("R5 threshold data", 96'(rx_data), 96'h5);
        chk("R7 spacing max-1 kept", 96'(rx_count), 96'd3);
        chk("R7 cause", 96'(rx_cause), 96'd1);
    endtask

    task automatic t_low_limit();
        logic [4:0] pat = 5'b01101;
        header(10, 5);
        for (int i = 0; i < 5; i++) send_bit(pat[i]);
        end_by_low();
        chk("R8 data", 96'(rx_data), 96'h0D);
        chk("R8 count", 96'(rx_count), 96'd5);
        chk("R8 cause excess low", 96'(rx_cause), 96'd2);
    endtask

    task automatic t_low_edge();
        header(10, 5);
        drive(1'b0, 5); drive(1'b1, 2);   // low equal to limit, spacing 7 -> 1
        drive(1'b0, 2); drive(1'b1, 2);   // spacing 4 -> 0
        end_by_cycle();
        chk("R8 low at limit keeps frame", 96'(rx_count), 96'd2);
        chk("R8 low at limit data", 96'(rx_data), 96'h1);
        chk("R8 low at limit cause", 96'(rx_cause), 96'd1);
    endtask

    task automatic t_overflow();
        logic [MAX_BITS-1:0] exp = '0;
        for (int i = 0; i < MAX_BITS; i++) exp[i] = (i % 3 == 0);
        header(10, 5);
        for (int i = 0; i < MAX_BITS + 3; i++) send_bit(i % 3 == 0);
        end_by_cycle();
        chk("R6 capped count", 96'(rx_count), 96'(MAX_BITS));
        chk("R6 overflow flag", 96'(rx_overflow), 96'd1);
        chk("R6 stored data", 96'(rx_data), 96'(exp));
    endtask

    task automatic t_reject();
        int l0 = n_ldr;
        int d0 = n_done;
        logic [MAX_BITS-1:0] dsave = rx_data;
        logic [NB_W-1:0]     csave = rx_count;
        header(6, 5);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_by_cycle();
        header(10, 9);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        end_by_cycle();
        chk("R4 no leader on bad widths", 96'(n_ldr - l0), 96'd0);
        chk("R4 no done on bad widths", 96'(n_done - d0), 96'd0);
        chk("R4 data held", 96'(rx_data), 96'(dsave));
        chk("R4 count held", 96'(rx_count), 96'(csave));
    endtask

    task automatic t_no_header();
        int d0 = n_done;
        logic [NB_W-1:0] csave = rx_count;
        for (int i = 0; i < 6; i++) send_bit(i[0]);
        end_by_low();
        chk("R10 no done without header", 96'(n_done - d0), 96'd0);
        chk("R10 count held", 96'(rx_count), 96'(csave));
    endtask

    task automatic t_glitch();
        header(10, 5);
        drive(1'b0, 2); drive(1'b1, 3); drive(1'b0, 1); drive(1'b1, 2);
        send_bit(1'b0);
        send_bit(1'b1);
        end_by_cycle();
        chk("R2 glitch count", 96'(rx_count), 96'd3);
        chk("R2 glitch data", 96'(rx_data), 96'h5);
    endtask

    task automatic t_enable();
        int d0 = n_done;
        header(10, 5);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        rx_enable = 1'b0;
        drive(1'b1, 5);
        rx_enable = 1'b1;
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        end_by_cycle();
        chk("R11 partial frame dropped", 96'(n_done - d0), 96'd0);
        header(10, 5);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        end_by_cycle();
        chk("R11 next frame count", 96'(rx_count), 96'd4);
        chk("R11 next frame data", 96'(rx_data), 96'h0);
    endtask

    task automatic t_no_ticks();
        int l0 = n_ldr;
        int d0 = n_done;
        tick_run = 1'b0;
        header(10, 5);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        end_by_cycle();
        tick_run = 1'b1;
        drive(1'b1, 30);
        chk("R1 no leader without ticks", 96'(n_ldr - l0), 96'd0);
        chk("R1 no done without ticks", 96'(n_done - d0), 96'd0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 10);
        t_reset();
        t_basic();
        t_thresholds();
        t_low_limit();
        t_low_edge();
        t_reject();
        t_no_header();
        t_glitch();
        t_enable();
        t_no_ticks();
        t_overflow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule